// File: doc/BRIEF.md
# Core Interval Timer with Auxiliary Register Port

This block is a per-core interval timer that software programs through a narrow auxiliary register port: a register number, write data, a write strobe and a combinational read-data return. Three registers are visible: a running count, a two-bit control word and a 32-bit limit. The count advances once per clock. When an advancing count equals the limit, it returns to zero and, if the interrupt-enable control bit is set, a level interrupt is latched toward the core.

A halt input from the core can freeze the count when the "count only while running" control bit is set. Software arms the timer by writing the limit, then zero into the count, then the control word with both bits set. Every control write acknowledges the pending interrupt. A handler that rewrites control with interrupt enable kept gives periodic operation. One that clears it gives one-shot operation.

Top module: `aux_interval_timer`

## Requirements
- R1: After reset the count, control and limit registers all read zero and `irq_o` is low.
- R2: Register numbers 0x21, 0x22 and 0x23 read the count, the control word and the limit. Control bit 0 is interrupt enable and bit 1 is halt gating; every other control bit reads zero. Any other register number reads zero. `rdata_o` follows `reg_num_i` in the same cycle.
- R3: The count grows by one on each clock edge, except when control bit 1 is set and `halt_i` is high. In that case the count holds.
- R4: A write to register 0x21 loads the written value at that edge, in place of that edge's increment. No wrap event happens on that edge.
- R5: Take a clock edge where the count advances and equals the limit. On that edge the count becomes zero. If control bit 0 was set before the edge, the interrupt is latched and `irq_o` is high after the edge.
- R6: A write of any value to register 0x22 clears the latched interrupt. The exception is a wrap with interrupt enable set on that same edge, which keeps it latched.
- R7: Rewriting control with bit 0 set leaves the count untouched. The next interrupt follows limit+1 advancing edges after the previous wrap (periodic use).
- R8: With control bit 0 clear, later wraps leave `irq_o` low (one-shot use).
- R9: `irq_o` is high only while the interrupt is latched and control bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | 1 | Core halted indication |
| reg_num_i | input | REG_W | Auxiliary register number |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe for the addressed register |
| rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt to the core |

## Verification
The hardest case to reach from the ports is a control-register acknowledge landing on the same edge as a wrap. In that case the new event must survive the clear. The stimulus arms the timer with a small limit and counts edges from the count reset. It then issues the control write on exactly the edge where the count passes the limit. Halt gating also needs care. The bench switches halt gating off while `halt_i` is still high, which shows that the gating bit governs that edge and not the pin alone.

// File: rtl/aux_timer_pkg.sv
package aux_timer_pkg;
   localparam int unsigned REG_COUNT_NUM = 32'h21;
   localparam int unsigned REG_CTRL_NUM  = 32'h22;
   localparam int unsigned REG_LIMIT_NUM = 32'h23;

   localparam int unsigned CTRL_IE_BIT   = 0;
   localparam int unsigned CTRL_NH_BIT   = 1;
   localparam int unsigned CTRL_FIELDS   = 2;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_CTRL  = 2'd2,
      SEL_LIMIT = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/aux_reg_decode.sv
module aux_reg_decode
   import aux_timer_pkg::*;
#(
   parameter int unsigned REG_W = 8
) (
   input  logic [REG_W-1:0] reg_num_i,
   input  logic             wr_i,
   output reg_sel_e         sel_o,
   output logic             wr_count_o,
   output logic             wr_ctrl_o,
   output logic             wr_limit_o
);
   localparam logic [REG_W-1:0] NUM_COUNT = REG_W'(REG_COUNT_NUM);
   localparam logic [REG_W-1:0] NUM_CTRL  = REG_W'(REG_CTRL_NUM);
   localparam logic [REG_W-1:0] NUM_LIMIT = REG_W'(REG_LIMIT_NUM);

   always_comb begin
      sel_o = SEL_NONE;
      if (reg_num_i == NUM_COUNT)      sel_o = SEL_COUNT;
      else if (reg_num_i == NUM_CTRL)  sel_o = SEL_CTRL;
      else if (reg_num_i == NUM_LIMIT) sel_o = SEL_LIMIT;
   end

   assign wr_count_o = wr_i && (sel_o == SEL_COUNT);
   assign wr_ctrl_o  = wr_i && (sel_o == SEL_CTRL);
   assign wr_limit_o = wr_i && (sel_o == SEL_LIMIT);
endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg
   import aux_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_ctrl_i,
   input  logic [DATA_W-1:0]      wdata_i,
   output logic [CTRL_FIELDS-1:0] ctrl_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)         ctrl_o <= '0;
      else if (wr_ctrl_i) ctrl_o <= wdata_i[CTRL_FIELDS-1:0];
   end
endmodule

// File: rtl/aux_count_unit.sv
module aux_count_unit #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance_i,
   input  logic              wr_count_i,
   input  logic              wr_limit_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] count_o,
   output logic [DATA_W-1:0] limit_o,
   output logic              wrap_o
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic at_limit;
   assign at_limit = (count_o == limit_o);
   assign wrap_o   = advance_i && !wr_count_i && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)          count_o <= '0;
      else if (wr_count_i) count_o <= wdata_i;
      else if (wrap_o)     count_o <= '0;
      else if (advance_i)  count_o <= count_o + ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          limit_o <= '0;
      else if (wr_limit_i) limit_o <= wdata_i;
   end
endmodule

// File: rtl/aux_irq_flag.sv
module aux_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap_i,
   input  logic ie_i,
   input  logic ack_i,
   output logic flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)              flag_o <= 1'b0;
      else if (wrap_i && ie_i) flag_o <= 1'b1;
      else if (ack_i)          flag_o <= 1'b0;
   end
endmodule

// File: rtl/aux_read_mux.sv
module aux_read_mux
   import aux_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  reg_sel_e               sel_i,
   input  logic [DATA_W-1:0]      count_i,
   input  logic [DATA_W-1:0]      limit_i,
   input  logic [CTRL_FIELDS-1:0] ctrl_i,
   output logic [DATA_W-1:0]      rdata_o
);
   logic [DATA_W-1:0] ctrl_word;

   for (genvar b = 0; b < DATA_W; b++) begin : g_ctrl_bit
      if (b < CTRL_FIELDS) begin : g_used
         assign ctrl_word[b] = ctrl_i[b];
      end else begin : g_zero
         assign ctrl_word[b] = 1'b0;
      end
   end

   always_comb begin
      unique case (sel_i)
         SEL_COUNT: rdata_o = count_i;
         SEL_CTRL:  rdata_o = ctrl_word;
         SEL_LIMIT: rdata_o = limit_i;
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/aux_interval_timer.sv
module aux_interval_timer
   import aux_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              halt_i,
   input  logic [REG_W-1:0]  reg_num_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              wr_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);
   if (DATA_W < CTRL_FIELDS) begin : g_bad_data_w
      $error("DATA_W must hold every control field");
   end
   if (REG_W < 6) begin : g_bad_reg_w
      $error("REG_W too narrow for the register numbers");
   end

   reg_sel_e               sel;
   logic                   wr_count, wr_ctrl, wr_limit;
   logic [CTRL_FIELDS-1:0] ctrl_bits;
   logic [DATA_W-1:0]      count_q, limit_q;
   logic                   wrap_evt, advance, flag_q;

   aux_reg_decode #(.REG_W(REG_W)) i_decode (
      .reg_num_i (reg_num_i),
      .wr_i      (wr_i),
      .sel_o     (sel),
      .wr_count_o(wr_count),
      .wr_ctrl_o (wr_ctrl),
      .wr_limit_o(wr_limit)
   );

   aux_ctrl_reg #(.DATA_W(DATA_W)) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl_i(wr_ctrl),
      .wdata_i  (wdata_i),
      .ctrl_o   (ctrl_bits)
   );

   assign advance = !(ctrl_bits[CTRL_NH_BIT] && halt_i);

   aux_count_unit #(.DATA_W(DATA_W)) i_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (advance),
      .wr_count_i(wr_count),
      .wr_limit_i(wr_limit),
      .wdata_i   (wdata_i),
      .count_o   (count_q),
      .limit_o   (limit_q),
      .wrap_o    (wrap_evt)
   );

   aux_irq_flag i_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .wrap_i(wrap_evt),
      .ie_i  (ctrl_bits[CTRL_IE_BIT]),
      .ack_i (wr_ctrl),
      .flag_o(flag_q)
   );

   aux_read_mux #(.DATA_W(DATA_W)) i_rmux (
      .sel_i  (sel),
      .count_i(count_q),
      .limit_i(limit_q),
      .ctrl_i (ctrl_bits),
      .rdata_o(rdata_o)
   );

   assign irq_o = flag_q && ctrl_bits[CTRL_IE_BIT];
endmodule

// File: rtl/aux_timer_checker.sv
module aux_timer_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halt_i,
   input logic [REG_W-1:0]  reg_num_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              wr_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [DATA_W-1:0] count_q,
   input logic [DATA_W-1:0] limit_q,
   input logic [1:0]        ctrl_bits
);
   logic cnt_wr, ctl_wr, frozen, hit, mapped;
   assign cnt_wr = wr_i && (reg_num_i == REG_W'(8'h21));
   assign ctl_wr = wr_i && (reg_num_i == REG_W'(8'h22));
   assign mapped = (reg_num_i == REG_W'(8'h21)) || (reg_num_i == REG_W'(8'h22)) ||
                   (reg_num_i == REG_W'(8'h23));
   assign frozen = ctrl_bits[1] && halt_i;
   assign hit    = !frozen && !cnt_wr && (count_q == limit_q);

   assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen && !cnt_wr) |=> (count_q == $past(count_q)));
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!frozen && !cnt_wr && count_q != limit_q) |=> (count_q == $past(count_q) + 1'b1));
   assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (count_q == $past(wdata_i)));
   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (count_q == '0));
   assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && ctrl_bits[0] && !ctl_wr) |=> irq_o);
   assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !(hit && ctrl_bits[0])) |=> !irq_o);
   assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ctrl_bits[0]);
   assert_unmapped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mapped) |-> (rdata_o == '0));
endmodule

bind aux_interval_timer aux_timer_checker #(.DATA_W(DATA_W), .REG_W(REG_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .halt_i   (halt_i),
   .reg_num_i(reg_num_i),
   .wdata_i  (wdata_i),
   .wr_i     (wr_i),
   .rdata_o  (rdata_o),
   .irq_o    (irq_o),
   .count_q  (count_q),
   .limit_q  (limit_q),
   .ctrl_bits(ctrl_bits)
);

// File: tb/test_aux_interval_timer.sv
`timescale 1ns/1ps
module test_aux_interval_timer;
   localparam int unsigned DW = 32;
   localparam int unsigned RW = 8;
   localparam logic [RW-1:0] N_CNT = 8'h21, N_CTL = 8'h22, N_LIM = 8'h23;
   localparam int NVEC = 4;
   localparam logic [DW-1:0] LIMS [NVEC] = '{32'd0, 32'd1, 32'd5, 32'd17};

   logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, wr = 1'b0;
   logic [RW-1:0] num = '0;
   logic [DW-1:0] wdata = '0, rdata;
   logic irq;
   int compared = 0, mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   aux_interval_timer #(.DATA_W(DW), .REG_W(RW)) i_aux_interval_timer (
      .clk(clk), .rst_n(rst_n), .halt_i(halt), .reg_num_i(num),
      .wdata_i(wdata), .wr_i(wr), .rdata_o(rdata), .irq_o(irq)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(logic [RW-1:0] n, output logic [DW-1:0] v);
      num = n; #1; v = rdata;
   endtask

   task automatic wreg(logic [RW-1:0] n, logic [DW-1:0] d);
      num = n; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic arm(logic [DW-1:0] lim);
      wreg(N_CTL, 32'h0);
      wreg(N_LIM, lim);
      wreg(N_CNT, 32'h0);
      wreg(N_CTL, 32'h3);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         mismatched++; compared++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] v;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd(N_CNT, v); check("R1 count", v, 0);
      rd(N_CTL, v); check("R1 ctrl", v, 0);
      rd(N_LIM, v); check("R1 limit", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
      // R2 map
      rd(8'h20, v); check("R2 unmapped", v, 0);
      wreg(N_CTL, 32'hFFFF_FFFF);
      rd(N_CTL, v); check("R2 ctrl unused bits", v, 32'h3);
      wreg(N_LIM, 32'hDEAD_BEEF);
      rd(N_LIM, v); check("R2 limit readback", v, 32'hDEAD_BEEF);

      // R5 table of limits
      for (int k = 0; k < NVEC; k++) begin
         arm(LIMS[k]);
         idle((LIMS[k] == 0) ? 0 : int'(LIMS[k]) - 1);
         rd(N_CNT, v); check("R5 count at limit", v, LIMS[k]);
         check("R5 irq before wrap", {31'b0, irq}, 0);
         idle(1);
         check("R5 irq after wrap", {31'b0, irq}, 1);
         rd(N_CNT, v); check("R5 count wrapped", v, 0);
      end

      // R7 periodic re-arm (limit 17)
      wreg(N_CTL, 32'h3);
      check("R7 ack clears", {31'b0, irq}, 0);
      rd(N_CNT, v); check("R7 count untouched", v, 1);
      idle(16);
      check("R7 no early irq", {31'b0, irq}, 0);
      idle(1);
      check("R7 periodic irq", {31'b0, irq}, 1);
      // R8 one-shot
      wreg(N_CTL, 32'h2);
      check("R8 ack", {31'b0, irq}, 0);
      idle(17);
      rd(N_CNT, v); check("R8 wrapped", v, 0);
      check("R8 no irq", {31'b0, irq}, 0);

      // R6 acknowledge on the wrap edge
      arm(32'd3);
      idle(2);
      wreg(N_CTL, 32'h3);
      check("R6 wrap beats ack", {31'b0, irq}, 1);
      wreg(N_CTL, 32'h3);
      check("R6 plain ack", {31'b0, irq}, 0);

      // R4 write priority
      wreg(N_LIM, 32'd1000);
      wreg(N_CNT, 32'd500);
      rd(N_CNT, v); check("R4 loaded", v, 500);
      idle(1);
      rd(N_CNT, v); check("R4 then increments", v, 501);

      // R3 halt gating
      halt = 1'b1;
      wreg(N_CNT, 32'd10);
      idle(5);
      rd(N_CNT, v); check("R3 frozen while halted", v, 10);
      wreg(N_CTL, 32'h1);
      idle(4);
      rd(N_CNT, v); check("R3 runs with gating off", v, 14);
      halt = 1'b0;
      // R9 irq needs enable
      check("R9 irq low", {31'b0, irq}, 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule